// File: doc/BRIEF.md
# GPIO Pin Interrupt Detection Unit

This block watches a bank of already-synchronised pin levels and turns their activity into latched interrupt status. Each pin gets a two-bit trigger mode: active-low level, active-high level, rising edge or falling edge. A separate per-pin override bit, available when the block is built with it, makes the pin trigger on either edge whatever its mode. Only pins whose direction bit marks them as inputs can set status. Edges are found by comparing the current sample with a stored copy of the previous cycle's sample, and that stored copy is updated on every clock.

Software configures the block through a small internal write port made of address, data and strobe, and reads it back through a combinational read port. Status bits are cleared by writing ones to them. Detection runs every cycle against the configuration currently held, so a change to direction, trigger mode or override takes effect on the cycle after the write. A pin still at its active level sets its bit again as soon as it is cleared. The unmasked status drives either one interrupt request or two, with the split between the lower and upper halves of the pins chosen at build time.

Top module: `gpio_irq_unit`

## Requirements
- R1: The trigger mode of pin n sits at bits 2n+1:2n of a 64-bit field. Address 1 reads and writes field bits 31:0, which cover pins 0 to 15. Address 2 covers field bits 63:32, which cover pins 16 to 31.
- R2: Mode 00 sets a pin's status bit in every cycle the pin is low. Mode 01 sets it in every cycle the pin is high.
- R3: Mode 10 sets the status bit when the pin goes from 0 to 1, and mode 11 sets it when the pin goes from 1 to 0. The bit is set on the clock edge that follows the change, and the change is measured against the level stored on the previous clock.
- R4: When a pin's override bit (address 5) is 1, a change in either direction sets its status bit and the trigger mode is ignored.
- R5: A pin whose direction bit (address 0) is 0 never sets its status bit.
- R6: Writing address 4 clears every status bit written as 1 and leaves bits written as 0 alone. A pin still at its active level stays set.
- R7: A write to direction, to either trigger word or to the override word takes effect from the next cycle, using the stored pin levels. A level-mode pin that is already active is flagged with no further pin activity. An edge-mode pin is not flagged unless its level changes.
- R8: With the split option off, irq_o[0] is the OR of status AND mask (address 3) over all pins and irq_o[1] is 0. With the split option on, irq_o[0] covers pins 15:0 and irq_o[1] covers pins 31:16.
- R9: When the block is built without the override, address 5 reads 0 and writes to it have no effect.
- R10: When a pin sets its status bit in the same cycle that a write clears that bit, the bit ends up set.
- R11: Reset clears direction, trigger, mask, status, override and the stored pin levels, so every read returns 0 and both requests are low.
- R12: Addresses 0 and 3 read back the last value written, address 4 reads the status, and addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_lvl_i | input | 32 | Synchronised pin levels |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 32 | Read data, combinational |
| irq_o | output | 2 | Interrupt requests |

## Verification
The two functions that can land on the same clock edge are a write-one-to-clear of a status bit and a new trigger event on that same bit. The bench provokes this in two ways. In one, it changes an edge-triggered pin on the same cycle as the clearing write. In the other, it clears a level-triggered pin that is still active. In both cases the bit must read 1 on the cycle after the write. Every other clear, where no event is present, must leave the bit at 0. A second build with the split requests and no override runs the same stimulus, so that the override and the request routing can be judged against the default build.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int PIN_CNT = 32;
    localparam int ADDR_W  = 3;

    typedef enum logic [2:0] {
        SEL_DIR     = 3'd0,
        SEL_TRIG_LO = 3'd1,
        SEL_TRIG_HI = 3'd2,
        SEL_MASK    = 3'd3,
        SEL_STATUS  = 3'd4,
        SEL_ANYEDGE = 3'd5
    } reg_sel_e;

    typedef enum logic [1:0] {
        TRIG_LOW  = 2'b00,
        TRIG_HIGH = 2'b01,
        TRIG_RISE = 2'b10,
        TRIG_FALL = 2'b11
    } trig_mode_e;

endpackage

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
    import gpio_irq_pkg::*;
#(
    parameter int NPINS       = PIN_CNT,
    parameter bit HAS_ANYEDGE = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  logic [ADDR_W-1:0]    wr_addr_i,
    input  logic [NPINS-1:0]     wr_data_i,
    input  logic [ADDR_W-1:0]    rd_addr_i,
    input  logic [NPINS-1:0]     status_i,
    output logic [NPINS-1:0]     dir_o,
    output logic [2*NPINS-1:0]   trig_o,
    output logic [NPINS-1:0]     mask_o,
    output logic [NPINS-1:0]     anyedge_o,
    output logic [NPINS-1:0]     clr_o,
    output logic [NPINS-1:0]     rd_data_o
);

    localparam int CFG_W = 2 * NPINS;

    typedef struct packed {
        logic [NPINS-1:0] dir;
        logic [CFG_W-1:0] trig;
        logic [NPINS-1:0] mask;
        logic [NPINS-1:0] anyedge;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic anyedge_wr_ok;

    generate
        if (HAS_ANYEDGE) begin : g_anyedge
            assign anyedge_wr_ok = 1'b1;
        end else begin : g_no_anyedge
            assign anyedge_wr_ok = 1'b0;
        end
    endgenerate

    // next-state: configuration writes and the clear mask
    always_comb begin
        cfg_d = cfg_q;
        clr_o = '0;
        if (wr_en_i) begin
            case (reg_sel_e'(wr_addr_i))
                SEL_DIR:     cfg_d.dir = wr_data_i;
                SEL_TRIG_LO: cfg_d.trig[NPINS-1:0] = wr_data_i;
                SEL_TRIG_HI: cfg_d.trig[CFG_W-1:NPINS] = wr_data_i;
                SEL_MASK:    cfg_d.mask = wr_data_i;
                SEL_STATUS:  clr_o = wr_data_i;
                SEL_ANYEDGE: begin
                    if (anyedge_wr_ok) begin
                        cfg_d.anyedge = wr_data_i;
                    end
                end
                default: ;
            endcase
        end
    end

    // read mux
    always_comb begin
        case (reg_sel_e'(rd_addr_i))
            SEL_DIR:     rd_data_o = cfg_q.dir;
            SEL_TRIG_LO: rd_data_o = cfg_q.trig[NPINS-1:0];
            SEL_TRIG_HI: rd_data_o = cfg_q.trig[CFG_W-1:NPINS];
            SEL_MASK:    rd_data_o = cfg_q.mask;
            SEL_STATUS:  rd_data_o = status_i;
            SEL_ANYEDGE: rd_data_o = cfg_q.anyedge;
            default:     rd_data_o = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign dir_o     = cfg_q.dir;
    assign trig_o    = cfg_q.trig;
    assign mask_o    = cfg_q.mask;
    assign anyedge_o = cfg_q.anyedge;

    AST_CLR_ONLY_ON_STATUS_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i || (wr_addr_i != SEL_STATUS)) |-> (clr_o == '0)); // R6

endmodule

// File: rtl/gpio_irq_lane.sv
module gpio_irq_lane
    import gpio_irq_pkg::*;
(
    input  logic       lvl_i,
    input  logic       prev_i,
    input  logic [1:0] mode_i,
    input  logic       any_i,
    input  logic       en_i,
    output logic       hit_o
);

    logic changed;
    logic raw;

    always_comb begin
        changed = lvl_i ^ prev_i;
        case (trig_mode_e'(mode_i))
            TRIG_LOW:  raw = ~lvl_i;
            TRIG_HIGH: raw = lvl_i;
            TRIG_RISE,
            TRIG_FALL: raw = changed & (lvl_i != mode_i[0]);
            default:   raw = 1'b0;
        endcase
        if (any_i) begin
            raw = changed;
        end
        hit_o = en_i & raw;
    end

endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status
    import gpio_irq_pkg::*;
#(
    parameter int NPINS     = PIN_CNT,
    parameter bit SPLIT_IRQ = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_lvl_i,
    input  logic [NPINS-1:0] hit_i,
    input  logic [NPINS-1:0] clr_i,
    input  logic [NPINS-1:0] mask_i,
    output logic [NPINS-1:0] status_o,
    output logic [NPINS-1:0] prev_o,
    output logic [1:0]       irq_o
);

    localparam int HALF = NPINS / 2;

    typedef struct packed {
        logic [NPINS-1:0] status;
        logic [NPINS-1:0] prev;
    } st_t;

    st_t st_d, st_q;
    logic [NPINS-1:0] pend;

    always_comb begin
        st_d        = st_q;
        // a new event outranks a clear of the same bit
        st_d.status = (st_q.status & ~clr_i) | hit_i;
        st_d.prev   = pin_lvl_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend     = st_q.status & mask_i;
    assign status_o = st_q.status;
    assign prev_o   = st_q.prev;

    generate
        if (SPLIT_IRQ) begin : g_split
            assign irq_o[0] = |pend[HALF-1:0];
            assign irq_o[1] = |pend[NPINS-1:HALF];
        end else begin : g_single
            assign irq_o = {1'b0, |pend};
        end
    endgenerate

    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i != '0) && ((clr_i & hit_i) == '0)) |=> ((st_q.status & $past(clr_i)) == '0)); // R6
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & hit_i) != '0) |=> ((st_q.status & $past(clr_i & hit_i)) == $past(clr_i & hit_i))); // R10
    AST_RISE_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.status & ~$past(st_q.status) & ~$past(hit_i)) == '0)); // R3
    AST_PREV_FOLLOWS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (st_q.prev == $past(pin_lvl_i))); // R3
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_i == '0) |-> (irq_o == 2'b00)); // R8

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
    import gpio_irq_pkg::*;
#(
    parameter int NPINS       = PIN_CNT,
    parameter bit HAS_ANYEDGE = 1'b1,
    parameter bit SPLIT_IRQ   = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPINS-1:0]  pin_lvl_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [NPINS-1:0]  wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [NPINS-1:0]  rd_data_o,
    output logic [1:0]        irq_o
);

    localparam int CFG_W = 2 * NPINS;

    logic [NPINS-1:0] dir, mask, anyedge, clr, status, prev, hit;
    logic [CFG_W-1:0] trig;

    gpio_irq_cfg #(
        .NPINS       (NPINS),
        .HAS_ANYEDGE (HAS_ANYEDGE)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .rd_addr_i (rd_addr_i),
        .status_i  (status),
        .dir_o     (dir),
        .trig_o    (trig),
        .mask_o    (mask),
        .anyedge_o (anyedge),
        .clr_o     (clr),
        .rd_data_o (rd_data_o)
    );

    generate
        for (genvar i = 0; i < NPINS; i++) begin : g_lane
            gpio_irq_lane u_lane (
                .lvl_i  (pin_lvl_i[i]),
                .prev_i (prev[i]),
                .mode_i (trig[2*i+1:2*i]),
                .any_i  (anyedge[i]),
                .en_i   (dir[i]),
                .hit_o  (hit[i])
            );
        end
    endgenerate

    gpio_irq_status #(
        .NPINS     (NPINS),
        .SPLIT_IRQ (SPLIT_IRQ)
    ) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_lvl_i (pin_lvl_i),
        .hit_i     (hit),
        .clr_i     (clr),
        .mask_i    (mask),
        .status_o  (status),
        .prev_o    (prev),
        .irq_o     (irq_o)
    );

    AST_HIT_NEEDS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        ((hit & ~dir) == '0)); // R5
    AST_NO_OVERRIDE_WHEN_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!HAS_ANYEDGE && (rd_addr_i == SEL_ANYEDGE)) |-> (rd_data_o == '0)); // R9

endmodule

// File: tb/sim_gpio_irq_unit.sv
`timescale 1ns/1ps
module sim_gpio_irq_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pins = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd0, rd1;
    logic [1:0]  irq0, irq1;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        int          sel;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t q[$];

    always #2 clk = ~clk;

    gpio_irq_unit u0 (
        .clk(clk), .rst_n(rst_n), .pin_lvl_i(pins), .wr_en_i(wr_en),
        .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
        .rd_data_o(rd0), .irq_o(irq0)
    );

    gpio_irq_unit #(.HAS_ANYEDGE(1'b0), .SPLIT_IRQ(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .pin_lvl_i(pins), .wr_en_i(wr_en),
        .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
        .rd_data_o(rd1), .irq_o(irq1)
    );

    // monitor: pops expected items and compares them with the outputs
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = q.pop_front();
                case (it.sel)
                    0:       act = rd0;
                    1:       act = {30'b0, irq0};
                    2:       act = rd1;
                    default: act = {30'b0, irq1};
                endcase
                n_run++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input int sel, input logic [2:0] a, input logic [31:0] e, input string tag);
        item_t it;
        rd_addr = a;
        it.sel = sel;
        it.exp = e;
        it.tag = tag;
        q.push_back(it);
        wait (q.size() == 0);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic chk_both(input logic [31:0] e, input string tag);
        chk(0, 3'd4, e, tag);
        chk(2, 3'd4, e, tag);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        for (int a = 0; a < 8; a++) chk(0, 3'(a), 32'h0, "R11 reset read");
        chk(1, 3'd0, 32'h0, "R11 reset irq u0");
        chk(3, 3'd0, 32'h0, "R11 reset irq u1");

        // R5: inputs disabled, low-level mode default, pins low
        tick();
        tick();
        chk_both(32'h0, "R5 no status without direction");

        // R1: trigger layout
        wr(3'd1, 32'hAAAA_AAE1);
        wr(3'd2, 32'hAAAA_AAA9);
        chk(0, 3'd1, 32'hAAAA_AAE1, "R1 low trigger word");
        chk(0, 3'd2, 32'hAAAA_AAA9, "R1 high trigger word");

        // R7/R2: enabling pins re-evaluates with stored levels
        wr(3'd0, 32'h0001_000F);
        chk(0, 3'd0, 32'h0001_000F, "R12 direction readback");
        tick();
        chk_both(32'h0000_0002, "R7 level pin flagged after direction write");

        // R6: clearing an active level pin re-sets it
        wr(3'd4, 32'h0000_0002);
        chk_both(32'h0000_0002, "R6 active level re-sets");

        // R2/R3/R1: high level, rising, rising-on-falling-mode, upper word pin
        pins[0] = 1'b1; pins[2] = 1'b1; pins[3] = 1'b1; pins[16] = 1'b1;
        tick();
        chk_both(32'h0001_0007, "R3 rise and R2 high and R1 pin16");
        chk(1, 3'd0, 32'h0, "R8 masked u0");
        chk(3, 3'd0, 32'h0, "R8 masked u1");

        wr(3'd3, 32'h0001_0000);
        chk(0, 3'd3, 32'h0001_0000, "R12 mask readback");
        chk(1, 3'd0, 32'h1, "R8 single irq upper pin");
        chk(3, 3'd0, 32'h2, "R8 split irq upper");
        wr(3'd3, 32'h0000_0004);
        chk(1, 3'd0, 32'h1, "R8 single irq lower pin");
        chk(3, 3'd0, 32'h1, "R8 split irq lower");

        // R3: falling edge
        pins[3] = 1'b0;
        tick();
        chk_both(32'h0001_000F, "R3 falling edge");

        // R6: clear edge bits
        wr(3'd4, 32'h0000_000C);
        chk_both(32'h0001_0003, "R6 clear edge bits");
        pins[0] = 1'b0;
        tick();
        wr(3'd4, 32'h0000_0001);
        chk_both(32'h0001_0002, "R6 clear inactive level bit");

        // R4 / R9: override
        wr(3'd5, 32'h0000_0004);
        chk(0, 3'd5, 32'h0000_0004, "R4 override readback");
        chk(2, 3'd5, 32'h0, "R9 override absent reads zero");
        pins[2] = 1'b0;
        tick();
        chk(0, 3'd4, 32'h0001_0006, "R4 override falling on rising pin");
        chk(2, 3'd4, 32'h0001_0002, "R9 write ignored, mode rules");

        // R10: set and clear in the same cycle
        wr(3'd4, 32'h0000_0004);
        chk_both(32'h0001_0002, "R6 clear before collision");
        @(negedge clk);
        pins[2] = 1'b1;
        wr_en = 1'b1;
        wr_addr = 3'd4;
        wr_data = 32'h0000_0004;
        @(negedge clk);
        wr_en = 1'b0;
        chk_both(32'h0001_0006, "R10 set wins over clear");

        // R5: disabled pin toggles
        pins[8] = 1'b1;
        tick();
        chk_both(32'h0001_0006, "R5 disabled pin edge ignored");

        // R7: mode change to active level
        wr(3'd1, 32'hAAAA_AAE0);
        tick();
        chk_both(32'h0001_0007, "R7 new level mode flagged");

        // R12: unused addresses
        chk(0, 3'd6, 32'h0, "R12 unused address");
        chk(0, 3'd7, 32'h0, "R12 unused address 7");

        wr(3'd3, 32'hFFFF_FFFF);
        chk(1, 3'd0, 32'h1, "R8 single irq all mask");
        chk(3, 3'd0, 32'h3, "R8 split irq both");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule